// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block is a memory-mapped pulse-width modulator with four independent outputs that all run from one input clock. Software programs it over a simple 32-bit register bus: a control word with per-output enable, polarity and drive-type bits, a period count and an active-time count for each output, and one shared word that packs a 6-bit clock divider for every output.

Each output divides the input clock by its own divider value plus one and steps a 16-bit position counter at that slower rate. The output is in its active state while the position is below the active-time count, and the counter wraps after the period count. Period, active-time and divider values are held in shadow copies that reload only at a period boundary, so a running waveform is never cut short by a register write.

Bus transfers take one cycle: a write lands at the clock edge where valid and write are both high, and a read returns its data on the bus read port from the following cycle on.

Top module: `quad_pwm_ctl`

## Requirements
- R1: After reset the enable and drive-type bits and all period, active-time and divider fields are zero, every polarity bit is 1, the control word reads 0x00000F00 and all four outputs are low.
- R2: A write is taken when valid and write are high at a clock edge and the byte address has its low two bits at zero. A read returns data one edge later. Control bits not assigned to a channel read as zero. Addresses 0x28 and above, and misaligned addresses, ignore writes and read as zero.
- R3: In the control word at 0x00, bit n enables channel n, bit 8+n is channel n's polarity, and bit 15+n is channel n's drive-type bit. The drive-type bit is only stored and read back.
- R4: Channel n's period count sits at 0x04+8n and its active-time count at 0x08+8n. Both use bits 15:0, and the upper bits read as zero.
- R5: The divider word at 0x24 holds channel n's 6-bit divider at bits (3-n)*6+5 down to (3-n)*6. Channel 0 uses bits 23:18 and channel 3 uses bits 5:0.
- R6: An enabled channel with divider P, period count C and active-time count D produces a period of (P+1)*C input clocks. The active portion is (P+1)*D clocks long.
- R7: With polarity 1 the active portion drives the output high. With polarity 0 it drives the output low.
- R8: An active-time count of 0 holds the output at its inactive level. An active-time count greater than or equal to the period count holds it at its active level.
- R9: A period count of 0 or 1 operates as a period count of 2.
- R10: A disabled channel drives its inactive level (low for polarity 1, high for polarity 0), holding its counters at zero. Setting the enable bit starts a fresh period whose active portion begins one clock after the enabling write's edge.
- R11: Period, active-time and divider writes to a running channel take effect at the next period boundary.
- R12: The four channels run independently, each with its own counts, divider and polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock for the bus and all channels |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus transfer request for this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| pwmOut | output | 4 | One waveform output per channel |

## Verification
A register write is visible at the edge where it is taken, read data appears one edge after the read, and an output reflects its channel's state one edge later still. For that reason, the first active clock after an enabling write is due on the second edge after the write is driven. Configuration changes to a running channel are due only after the period that is under way has finished. The bench drives inputs and samples every output on the falling clock edge. It compares run lengths counted from edge to edge of an output rather than absolute times. For constant levels, it lets more than one full period pass before sampling, and in the boundary test it starts writes inside a measured high phase so that the old and the new period can both be seen.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int CNT_W      = 16;
  localparam int PS_W       = 6;
  localparam int DATA_W     = 32;
  localparam int MIN_PERIOD = 2;
  localparam int EN_LSB     = 0;
  localparam int POL_LSB    = 8;
  localparam int DRV_LSB    = 15;

  // Configuration bundle handed from the register side to one channel
  typedef struct packed {
    logic             en;
    logic             activeHigh;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic [PS_W-1:0]  prescale;
  } chanCfg_t;
endpackage

// File: rtl/qpwm_ctrl.sv
module qpwm_ctrl
  import qpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busValid,
  input  logic                     busWrite,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  output chanCfg_t [NUM_CH-1:0]    cfg
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int PS_IDX = 1 + 2 * NUM_CH;

  function automatic logic [DATA_W-1:0] ctrlMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      m[EN_LSB + n]  = 1'b1;
      m[POL_LSB + n] = 1'b1;
      m[DRV_LSB + n] = 1'b1;
    end
    return m;
  endfunction
  localparam logic [DATA_W-1:0] CTRL_MASK = ctrlMask();

  logic [NUM_CH-1:0] enQ, polQ, drvQ;
  logic [CNT_W-1:0]  periodQ [NUM_CH];
  logic [CNT_W-1:0]  dutyQ   [NUM_CH];
  logic [PS_W-1:0]   psQ     [NUM_CH];
  logic [DATA_W-1:0] rdNext;

  logic [IDX_W-1:0] idx;
  logic             wordOk, wrEn, rdEn;

  assign idx    = busAddr[ADDR_W-1:2];
  assign wordOk = (busAddr[1:0] == 2'b00);
  assign wrEn   = busValid && busWrite && wordOk;
  assign rdEn   = busValid && !busWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      polQ <= '1;
      drvQ <= '0;
      for (int n = 0; n < NUM_CH; n++) begin
        periodQ[n] <= '0;
        dutyQ[n]   <= '0;
        psQ[n]     <= '0;
      end
    end else if (wrEn) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (int'(idx) == 0) begin
          enQ[n]  <= busWdata[EN_LSB + n];
          polQ[n] <= busWdata[POL_LSB + n];
          drvQ[n] <= busWdata[DRV_LSB + n];
        end
        if (int'(idx) == 1 + 2 * n) periodQ[n] <= busWdata[CNT_W-1:0];
        if (int'(idx) == 2 + 2 * n) dutyQ[n]   <= busWdata[CNT_W-1:0];
        if (int'(idx) == PS_IDX)
          psQ[n] <= busWdata[(NUM_CH-1-n)*PS_W +: PS_W];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (wordOk) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (int'(idx) == 0) begin
          rdNext[EN_LSB + n]  = enQ[n];
          rdNext[POL_LSB + n] = polQ[n];
          rdNext[DRV_LSB + n] = drvQ[n];
        end
        if (int'(idx) == 1 + 2 * n) rdNext[CNT_W-1:0] = periodQ[n];
        if (int'(idx) == 2 + 2 * n) rdNext[CNT_W-1:0] = dutyQ[n];
        if (int'(idx) == PS_IDX)
          rdNext[(NUM_CH-1-n)*PS_W +: PS_W] = psQ[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      busRdata <= '0;
    else if (rdEn)  busRdata <= rdNext;
  end

  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      cfg[n].en         = enQ[n];
      cfg[n].activeHigh = polQ[n];
      cfg[n].period     = periodQ[n];
      cfg[n].duty       = dutyQ[n];
      cfg[n].prescale   = psQ[n];
    end
  end

  // R2: unassigned control bits never show up on a read
  p_ctrl_unused_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wordOk && idx == '0) |=> ((busRdata & ~CTRL_MASK) == '0));

  // R2: undefined or misaligned addresses read as zero
  p_undef_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (!wordOk || int'(idx) > PS_IDX)) |=> (busRdata == '0));

  // R4: period field of channel 0 changes only through its own address
  p_period_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && int'(idx) == 1) |=> $stable(periodQ[0]));
endmodule

// File: rtl/qpwm_chan.sv
module qpwm_chan
  import qpwm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanCfg_t cfg,
  output logic     pwmOut
);
  logic [CNT_W-1:0] cnt, shPc, shDc, pcEff;
  logic [PS_W-1:0]  psCnt, shPs;
  logic             tick, wrap;

  assign pcEff = (cfg.period < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : cfg.period;
  assign tick  = (psCnt == shPs);
  assign wrap  = tick && (cnt == shPc - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      psCnt  <= '0;
      shPc   <= CNT_W'(MIN_PERIOD);
      shDc   <= '0;
      shPs   <= '0;
      pwmOut <= 1'b0;
    end else begin
      if (!cfg.en) begin
        cnt   <= '0;
        psCnt <= '0;
        shPc  <= pcEff;
        shDc  <= cfg.duty;
        shPs  <= cfg.prescale;
      end else if (tick) begin
        psCnt <= '0;
        if (wrap) begin
          cnt  <= '0;
          shPc <= pcEff;
          shDc <= cfg.duty;
          shPs <= cfg.prescale;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        psCnt <= psCnt + 1'b1;
      end
      pwmOut <= cfg.en ? ((cnt < shDc) == cfg.activeHigh) : !cfg.activeHigh;
    end
  end

  // R6: position counter stays inside the latched period
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    cnt < shPc);

  // R6: divider counter never passes its latched limit
  p_ps_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    psCnt <= shPs);

  // R9: latched period is never below two
  p_min_period_r9: assert property (@(posedge clk) disable iff (!rstN)
    shPc >= CNT_W'(MIN_PERIOD));

  // R10: a disabled channel shows its inactive level next cycle
  p_idle_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.en |=> (pwmOut == !$past(cfg.activeHigh)));

  // R11: latched settings move only at a period boundary or while idle
  p_boundary_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && !wrap) |=> ($stable(shPc) && $stable(shDc) && $stable(shPs)));
endmodule

// File: rtl/qpwm_datapath.sv
module qpwm_datapath
  import qpwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chanCfg_t [NUM_CH-1:0] cfg,
  output logic [NUM_CH-1:0]     pwmOut
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    qpwm_chan u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .cfg    (cfg[n]),
      .pwmOut (pwmOut[n])
    );
  end
endmodule

// File: rtl/quad_pwm_ctl.sv
module quad_pwm_ctl
  import qpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_CH-1:0]  pwmOut
);
  chanCfg_t [NUM_CH-1:0] cfg;

  qpwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .cfg      (cfg)
  );

  qpwm_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cfg    (cfg),
    .pwmOut (pwmOut)
  );
endmodule

// File: tb/quad_pwm_ctl_bench.sv
`timescale 1ns/1ps
module quad_pwm_ctl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  pwmOut;

  always #4 clk = ~clk;

  quad_pwm_ctl u_quad_pwm_ctl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  typedef struct { int ch; int hi; int lo; string tag; } expItem_t;
  expItem_t expQ[$];
  int  errors = 0;
  int  checks = 0;
  bit  finished = 1'b0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic waitLevel(int ch, bit lvl);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (pwmOut[ch] == lvl) return;
    end
  endtask

  // Counts consecutive falling-edge samples at lvl, starting with the current one
  task automatic runLen(int ch, bit lvl, output int n);
    n = 0;
    while (pwmOut[ch] == lvl && n < 3000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic push(int ch, int hi, int lo, string tag);
    expItem_t e;
    e.ch = ch; e.hi = hi; e.lo = lo; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic drain();
    wait (expQ.size() == 0);
  endtask

  // Monitor: pops expected waveforms and measures them on the outputs
  initial begin
    expItem_t e;
    int h, l, bad;
    bit lvl;
    forever begin
      wait (expQ.size() > 0);
      e = expQ[0];
      if (e.hi == 0 || e.lo == 0) begin
        lvl = (e.lo == 0);
        repeat (80) @(negedge clk);
        bad = 0;
        repeat (80) begin
          @(negedge clk);
          if (pwmOut[e.ch] != lvl) bad++;
        end
        chk(bad == 0, {e.tag, " constant level"}, bad, 0);
      end else begin
        waitLevel(e.ch, 1'b0);
        waitLevel(e.ch, 1'b1);
        runLen(e.ch, 1'b1, h);
        runLen(e.ch, 1'b0, l);
        chk(h == e.hi, {e.tag, " high time"}, h, e.hi);
        chk(l == e.lo, {e.tag, " low time"}, l, e.lo);
      end
      void'(expQ.pop_front());
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h, l;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pwmOut == 4'b0000, "R1 outputs low after reset", pwmOut, 0);
    busRd(6'h00, d); chk(d == 32'h0000_0F00, "R1 control reset", d, 32'h0000_0F00);
    busRd(6'h24, d); chk(d == 32'h0, "R1 divider reset", d, 0);
    busRd(6'h04, d); chk(d == 32'h0, "R1 period reset", d, 0);

    // R2 R3 control layout and unused bits
    busWr(6'h00, 32'hFFFF_FFFF);
    busRd(6'h00, d); chk(d == 32'h0007_8F0F, "R3 R2 control readback mask", d, 32'h0007_8F0F);
    busWr(6'h00, 32'h0000_0F00);

    // R4 count registers
    busWr(6'h0C, 32'h1234_ABCD);
    busRd(6'h0C, d); chk(d == 32'h0000_ABCD, "R4 period ch1 16-bit", d, 32'hABCD);
    busWr(6'h20, 32'h0000_5A5A);
    busRd(6'h20, d); chk(d == 32'h0000_5A5A, "R4 duty ch3", d, 32'h5A5A);
    busRd(6'h1C, d); chk(d == 32'h0, "R4 period ch3 untouched", d, 0);

    // R2 undefined and misaligned addresses
    busWr(6'h28, 32'hFFFF_FFFF);
    busRd(6'h28, d); chk(d == 32'h0, "R2 undefined offset reads zero", d, 0);
    busWr(6'h0D, 32'h0000_1111);
    busRd(6'h0C, d); chk(d == 32'h0000_ABCD, "R2 misaligned write ignored", d, 32'hABCD);
    busRd(6'h0D, d); chk(d == 32'h0, "R2 misaligned read zero", d, 0);

    // R5 divider packing
    busWr(6'h24, 32'hFFFF_FFFF);
    busRd(6'h24, d); chk(d == 32'h00FF_FFFF, "R5 divider word mask", d, 32'h00FF_FFFF);

    // R5 R6 R7 R12 four different waveforms at once
    busWr(6'h24, (32'd2 << 18) | (32'd0 << 12) | (32'd1 << 6) | 32'd3);
    busWr(6'h04, 10); busWr(6'h08, 3);
    busWr(6'h0C, 8);  busWr(6'h10, 5);
    busWr(6'h14, 6);  busWr(6'h18, 2);
    busWr(6'h1C, 4);  busWr(6'h20, 1);
    busWr(6'h00, 32'h0000_050F);
    push(0, 9, 21, "R5 R6 ch0 divider 2");
    push(1, 3, 5,  "R7 R12 ch1 inverted");
    push(2, 4, 8,  "R6 R12 ch2 divider 1");
    push(3, 12, 4, "R5 R7 ch3 divider 3 inverted");
    drain();

    // R8 duty extremes
    busWr(6'h18, 0);
    busWr(6'h08, 10);
    push(2, 0, 1, "R8 ch2 duty zero");
    push(0, 1, 0, "R8 ch0 duty equals period");
    drain();

    // R9 short periods
    busWr(6'h0C, 1); busWr(6'h10, 1);
    push(1, 1, 1, "R9 ch1 period one");
    drain();
    busWr(6'h0C, 0);
    push(1, 1, 1, "R9 ch1 period zero");
    drain();

    // R10 disabled channel idles at its inactive level
    busWr(6'h00, 32'h0000_0507);
    push(3, 1, 0, "R10 ch3 disabled inverted idles high");
    drain();
    busWr(6'h24, 32'h0000_0040);
    busWr(6'h1C, 5); busWr(6'h20, 2);
    busWr(6'h00, 32'h0000_0D07);
    repeat (2) @(negedge clk);
    chk(pwmOut[3] == 1'b0, "R10 ch3 disabled normal idles low", pwmOut[3], 0);
    busWr(6'h00, 32'h0000_0D0F);
    chk(pwmOut[3] == 1'b0, "R10 output still idle at enabling edge", pwmOut[3], 0);
    @(negedge clk);
    chk(pwmOut[3] == 1'b1, "R10 fresh period active one clock later", pwmOut[3], 1);
    runLen(3, 1'b1, h);
    runLen(3, 1'b0, l);
    chk(h == 2, "R10 fresh period high time", h, 2);
    chk(l == 3, "R10 fresh period low time", l, 3);

    // R11 writes land at the period boundary
    busWr(6'h04, 40); busWr(6'h08, 10);
    repeat (80) @(negedge clk);
    waitLevel(0, 1'b0);
    waitLevel(0, 1'b1);
    begin
      int h1, l1, h2, l2;
      fork
        begin busWr(6'h04, 10); busWr(6'h08, 5); end
        begin
          runLen(0, 1'b1, h1); runLen(0, 1'b0, l1);
          runLen(0, 1'b1, h2); runLen(0, 1'b0, l2);
        end
      join
      chk(h1 == 10, "R11 current high kept", h1, 10);
      chk(l1 == 30, "R11 current period completes", l1, 30);
      chk(h2 == 5,  "R11 new high after boundary", h2, 5);
      chk(l2 == 5,  "R11 new low after boundary", l2, 5);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule